// File: doc/BRIEF.md
# Monitor Lock Enter/Exit Unit

This unit performs the fast path of the monitor enter, exit and re-enter operations on a 16-bit lock word held in shared memory. A caller presents an operation code, the lock-word address and two extra operand words. The unit reads the lock word. Where the fast path applies, it writes the new value back and returns a status word. Every other case is passed to a software handler: the unit makes no memory update and issues a one-cycle handoff pulse that carries the operation and three operand words.

In the lock word, the top bit set with all other bits clear (16'h8000) means free, and zero means held with no waiters. Any other value means waiters are queued, and only software may resolve that case. Re-enter first reads a global slow-path flag word at a fixed address. If that word is nonzero, the request goes straight to software; if it is zero, re-enter behaves as enter.

The memory port uses a request/grant handshake, and read data returns one cycle after a granted read. A lock output is raised from the cycle after the granted lock read until the write-back is granted. An arbiter keeps other masters off the memory for as long as that output is high, so the read-modify-write is atomic.

Top module: `mlock_unit`

## Requirements
- R1: While reset is active and whenever the unit is idle, busy, mem_req, mem_lock, resp_valid and hand_valid are all low.
- R2: Enter (op 2'b00) on a lock word of 16'h8000 writes 16'h0000 to that word and returns resp_status 1 with resp_slow low.
- R3: Enter on any lock word other than 16'h8000 writes nothing and hands off with hand_op 2'b00, hand_w0 equal to the lock address zero-extended, and hand_w1/hand_w2 equal to the request's two operand words.
- R4: Exit (op 2'b01) on a lock word of 16'h0000 writes 16'h8000 and returns resp_status 0 with resp_slow low.
- R5: Exit on a nonzero lock word, including 16'h8000, writes nothing and hands off with hand_op 2'b01.
- R6: Re-enter (op 2'b10) reads the slow-path flag word at address SLOW_ADDR. If that word is nonzero, the unit hands off with hand_op 2'b10 without reading or writing the lock word.
- R7: Re-enter with a zero flag word then follows the enter rules of R2 and R3, returning status 1 on the fast path.
- R8: mem_lock rises in the cycle after the granted lock read and stays high until the write-back is granted. A lock write is never issued while mem_lock is low.
- R9: A handoff is a single-cycle hand_valid pulse that coincides with resp_valid and resp_slow.
- R10: A memory request that has not been granted stays asserted with the same address and direction until it is granted.
- R11: A request presented while busy is high is ignored and leaves memory untouched.
- R12: Op code 2'b11 is reserved and is handed off at once, with no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, accepted when busy is low |
| req_op | input | 2 | 00 enter, 01 exit, 10 re-enter, 11 reserved |
| req_addr | input | AW | Lock-word address |
| req_arg1 | input | DW | Extra operand passed on a handoff |
| req_arg2 | input | DW | Extra operand passed on a handoff |
| busy | output | 1 | Operation in progress |
| resp_valid | output | 1 | One-cycle completion strobe |
| resp_status | output | DW | Status value (1 entered, 0 exited or handed off) |
| resp_slow | output | 1 | The completion is a software handoff |
| mem_req | output | 1 | Memory access request |
| mem_gnt | input | 1 | Memory access granted this cycle |
| mem_we | output | 1 | The access is a write |
| mem_lock | output | 1 | Hold the memory grant for the read-modify-write |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid the cycle after a granted read |
| hand_valid | output | 1 | Handoff pulse |
| hand_op | output | 2 | Operation being handed off |
| hand_w0 | output | DW | Lock address, zero-extended |
| hand_w1 | output | DW | First extra operand |
| hand_w2 | output | DW | Second extra operand |

## Verification
Latency is counted from the clock edge that accepts a request, with no grant stalls:

| Case | resp_valid due after |
|---|---|
| Reserved op handoff | 1 edge |
| Enter or exit handoff | 3 edges |
| Re-enter with a set flag | 3 edges |
| Enter or exit fast path | 4 edges |
| Re-enter handoff after reading the lock | 5 edges |
| Re-enter fast path | 6 edges |

Each stalled grant adds one edge. The bench samples at the falling edge after each rising edge and compares the cycle where the response appears against these counts, so an early or late result fails as well as a wrong value. In the stall test, grants are withheld for three cycles during the write-back. The bench checks that mem_req and mem_lock stay high through that window and that the response arrives three edges late.

// File: rtl/mlock_pkg.sv
package mlock_pkg;

  typedef enum logic [1:0] {
    OP_ENTER   = 2'b00,
    OP_EXIT    = 2'b01,
    OP_REENTER = 2'b10,
    OP_RSVD    = 2'b11
  } mlock_op_e;

  typedef enum logic [2:0] {
    S_IDLE    = 3'd0,
    S_FLAG_RD = 3'd1,
    S_FLAG_WT = 3'd2,
    S_LOCK_RD = 3'd3,
    S_LOCK_WT = 3'd4,
    S_LOCK_WR = 3'd5,
    S_RESP    = 3'd6,
    S_HAND    = 3'd7
  } mlock_st_e;

endpackage

// File: rtl/mlock_decide.sv
// Pure decision: given the operation and the lock word just read, say
// whether the fast path applies, what to write back and what to return.
module mlock_decide
  import mlock_pkg::*;
#(
  parameter int DW = 16
) (
  input  mlock_op_e         op,
  input  logic [DW-1:0]     word,
  output logic              fast,
  output logic [DW-1:0]     new_word,
  output logic [DW-1:0]     new_status
);
  localparam logic [DW-1:0] FREE_WORD = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] HELD_WORD = '0;

  always_comb begin
    fast       = 1'b0;
    new_word   = HELD_WORD;
    new_status = '0;
    case (op)
      OP_ENTER, OP_REENTER: begin
        fast       = (word == FREE_WORD);
        new_word   = HELD_WORD;
        new_status = {{(DW-1){1'b0}}, 1'b1};
      end
      OP_EXIT: begin
        fast       = (word == HELD_WORD);
        new_word   = FREE_WORD;
        new_status = '0;
      end
      default: begin
        fast = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/mlock_capture.sv
// Holds the operands of the accepted request for the lock access and
// for the software handoff.
module mlock_capture
  import mlock_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  mlock_op_e     op_in,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] arg1_in,
  input  logic [DW-1:0] arg2_in,
  output mlock_op_e     op_q,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] w0,
  output logic [DW-1:0] w1,
  output logic [DW-1:0] w2
);
  logic [DW-1:0] arg1_q, arg2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_ENTER;
      addr_q <= '0;
      arg1_q <= '0;
      arg2_q <= '0;
    end else if (load) begin
      op_q   <= op_in;
      addr_q <= addr_in;
      arg1_q <= arg1_in;
      arg2_q <= arg2_in;
    end
  end

  always_comb begin
    w0         = '0;
    w0[AW-1:0] = addr_q;
    w1         = arg1_q;
    w2         = arg2_q;
  end

endmodule

// File: rtl/mlock_ctrl.sv
// Sequencer: flag read (re-enter only), locked read, conditional write,
// then one response or handoff cycle.
module mlock_ctrl
  import mlock_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  mlock_op_e     start_op,
  input  logic [DW-1:0] rd_word,
  input  logic          fast,
  input  logic [DW-1:0] new_word,
  input  logic [DW-1:0] new_status,
  input  logic          mem_gnt,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_lock,
  output logic          sel_flag,
  output logic [DW-1:0] wdata,
  output logic [DW-1:0] status,
  output logic          resp_valid,
  output logic          resp_slow,
  output logic          hand_valid
);
  mlock_st_e     st_q, st_nx;
  logic          res_en;
  logic [DW-1:0] wdata_nx, status_nx;

  always_comb begin
    st_nx     = st_q;
    res_en    = 1'b0;
    wdata_nx  = wdata;
    status_nx = status;
    case (st_q)
      S_IDLE: begin
        if (start) begin
          case (start_op)
            OP_REENTER:      st_nx = S_FLAG_RD;
            OP_ENTER, OP_EXIT: st_nx = S_LOCK_RD;
            default: begin
              st_nx     = S_HAND;
              res_en    = 1'b1;
              status_nx = '0;
            end
          endcase
        end
      end
      S_FLAG_RD: if (mem_gnt) st_nx = S_FLAG_WT;
      S_FLAG_WT: begin
        if (rd_word != '0) begin
          st_nx     = S_HAND;
          res_en    = 1'b1;
          status_nx = '0;
        end else begin
          st_nx = S_LOCK_RD;
        end
      end
      S_LOCK_RD: if (mem_gnt) st_nx = S_LOCK_WT;
      S_LOCK_WT: begin
        res_en = 1'b1;
        if (fast) begin
          st_nx     = S_LOCK_WR;
          wdata_nx  = new_word;
          status_nx = new_status;
        end else begin
          st_nx     = S_HAND;
          status_nx = '0;
        end
      end
      S_LOCK_WR: if (mem_gnt) st_nx = S_RESP;
      default:   st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      wdata  <= '0;
      status <= '0;
    end else begin
      st_q <= st_nx;
      if (res_en) begin
        wdata  <= wdata_nx;
        status <= status_nx;
      end
    end
  end

  always_comb begin
    busy       = (st_q != S_IDLE);
    mem_req    = (st_q == S_FLAG_RD) || (st_q == S_LOCK_RD) || (st_q == S_LOCK_WR);
    mem_we     = (st_q == S_LOCK_WR);
    sel_flag   = (st_q == S_FLAG_RD);
    mem_lock   = (st_q == S_LOCK_WT) || (st_q == S_LOCK_WR);
    hand_valid = (st_q == S_HAND);
    resp_slow  = (st_q == S_HAND);
    resp_valid = (st_q == S_RESP) || (st_q == S_HAND);
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_we) && $stable(sel_flag))); // R10
  AST_WRITE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_lock); // R8
  AST_LOCK_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_lock) |-> $past(mem_req && mem_gnt && !mem_we && !sel_flag)); // R8
  AST_HAND_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    hand_valid |=> !hand_valid); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !mem_lock && !resp_valid)); // R1
  AST_FAST_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_slow) |-> $past(mem_req && mem_gnt && mem_we)); // R2

endmodule

// File: rtl/mlock_unit.sv
module mlock_unit
  import mlock_pkg::*;
#(
  parameter int              AW        = 8,
  parameter int              DW        = 16,
  parameter logic [AW-1:0]   SLOW_ADDR = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_arg1,
  input  logic [DW-1:0] req_arg2,
  output logic          busy,
  output logic          resp_valid,
  output logic [DW-1:0] resp_status,
  output logic          resp_slow,
  output logic          mem_req,
  input  logic          mem_gnt,
  output logic          mem_we,
  output logic          mem_lock,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          hand_valid,
  output logic [1:0]    hand_op,
  output logic [DW-1:0] hand_w0,
  output logic [DW-1:0] hand_w1,
  output logic [DW-1:0] hand_w2
);
  localparam logic [DW-1:0] FREE_WORD = {1'b1, {(DW-1){1'b0}}};

  logic [1:0]    rs_q;
  logic          rst_n_s;
  logic          start, fast, sel_flag;
  mlock_op_e     op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] new_word, new_status;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  assign start    = req_valid && !busy;
  assign mem_addr = sel_flag ? SLOW_ADDR : addr_q;
  assign hand_op  = op_q;

  mlock_capture #(.AW(AW), .DW(DW)) u_cap (
    .clk(clk), .rst_n(rst_n_s), .load(start),
    .op_in(mlock_op_e'(req_op)), .addr_in(req_addr),
    .arg1_in(req_arg1), .arg2_in(req_arg2),
    .op_q(op_q), .addr_q(addr_q),
    .w0(hand_w0), .w1(hand_w1), .w2(hand_w2)
  );

  mlock_decide #(.DW(DW)) u_dec (
    .op(op_q), .word(mem_rdata),
    .fast(fast), .new_word(new_word), .new_status(new_status)
  );

  mlock_ctrl #(.DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n_s), .start(start),
    .start_op(mlock_op_e'(req_op)), .rd_word(mem_rdata),
    .fast(fast), .new_word(new_word), .new_status(new_status),
    .mem_gnt(mem_gnt), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
    .mem_lock(mem_lock), .sel_flag(sel_flag), .wdata(mem_wdata),
    .status(resp_status), .resp_valid(resp_valid), .resp_slow(resp_slow),
    .hand_valid(hand_valid)
  );

  AST_WDATA_VALUE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mem_req && mem_we) |-> (mem_wdata == ((op_q == OP_EXIT) ? FREE_WORD : '0))); // R4
  AST_FAST_STATUS: assert property (@(posedge clk) disable iff (!rst_n_s)
    (resp_valid && !resp_slow) |-> (resp_status == ((op_q == OP_EXIT) ? '0 : DW'(1)))); // R7
  AST_RSVD_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mem_req && (op_q == OP_RSVD)) |-> 1'b0); // R12

endmodule

// File: tb/mlock_unit_tb.sv
`timescale 1ns/1ps
module mlock_unit_tb;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam logic [7:0] FLAG_A = 8'hFF;

  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  addr;
    logic [15:0] init;
    logic [15:0] flag;
    logic [3:0]  lat;
    logic [15:0] st;
    logic        slow;
    logic [15:0] fin;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [0:NV-1] = '{
    '{2'd0, 8'h10, 16'h8000, 16'h0000, 4'd4, 16'h0001, 1'b0, 16'h0000}, // R2
    '{2'd0, 8'h11, 16'h0000, 16'h0000, 4'd3, 16'h0000, 1'b1, 16'h0000}, // R3
    '{2'd0, 8'h12, 16'h0042, 16'h0000, 4'd3, 16'h0000, 1'b1, 16'h0042}, // R3
    '{2'd1, 8'h13, 16'h0000, 16'h0000, 4'd4, 16'h0000, 1'b0, 16'h8000}, // R4
    '{2'd1, 8'h14, 16'h0005, 16'h0000, 4'd3, 16'h0000, 1'b1, 16'h0005}, // R5
    '{2'd1, 8'h15, 16'h8000, 16'h0000, 4'd3, 16'h0000, 1'b1, 16'h8000}, // R5
    '{2'd2, 8'h16, 16'h8000, 16'h0000, 4'd6, 16'h0001, 1'b0, 16'h0000}, // R7
    '{2'd2, 8'h17, 16'h8000, 16'h0001, 4'd3, 16'h0000, 1'b1, 16'h8000}, // R6
    '{2'd2, 8'h18, 16'h0003, 16'h0000, 4'd5, 16'h0000, 1'b1, 16'h0003}, // R7
    '{2'd3, 8'h19, 16'h8000, 16'h0000, 4'd1, 16'h0000, 1'b1, 16'h8000}, // R12
    '{2'd0, 8'h1A, 16'h8001, 16'h0000, 4'd3, 16'h0000, 1'b1, 16'h8001}  // R3
  };

  logic clk, rst_n;
  logic req_valid;
  logic [1:0] req_op;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_arg1, req_arg2;
  logic busy, resp_valid, resp_slow, mem_req, mem_gnt, mem_we, mem_lock, hand_valid;
  logic [DW-1:0] resp_status, mem_wdata, mem_rdata, hand_w0, hand_w1, hand_w2;
  logic [AW-1:0] mem_addr;
  logic [1:0] hand_op;

  logic stall;
  logic tb_we;
  logic [7:0] tb_wa;
  logic [15:0] tb_wd;
  logic [15:0] mem [0:255];
  int wr_cnt = 0;
  int rd_cnt = 0;
  int lock_bad = 0;
  int checks = 0;
  int errors = 0;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  assign mem_gnt = mem_req && !stall;

  always @(posedge clk) begin
    if (tb_we) mem[tb_wa] <= tb_wd;
    else if (mem_req && mem_gnt) begin
      if (mem_we) begin
        mem[mem_addr] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        mem_rdata <= mem[mem_addr];
        rd_cnt <= rd_cnt + 1;
      end
    end
    if (mem_req && mem_gnt && mem_we && !mem_lock) lock_bad <= lock_bad + 1;
  end

  mlock_unit #(.AW(AW), .DW(DW), .SLOW_ADDR(FLAG_A)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_arg1(req_arg1), .req_arg2(req_arg2),
    .busy(busy), .resp_valid(resp_valid), .resp_status(resp_status),
    .resp_slow(resp_slow), .mem_req(mem_req), .mem_gnt(mem_gnt),
    .mem_we(mem_we), .mem_lock(mem_lock), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .hand_valid(hand_valid),
    .hand_op(hand_op), .hand_w0(hand_w0), .hand_w1(hand_w1), .hand_w2(hand_w2)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic poke(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    tb_we = 1'b1; tb_wa = a; tb_wd = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  // drives one request; returns the falling edge count at which resp_valid appeared
  task automatic issue(input logic [1:0] op, input logic [7:0] a,
                       input logic [15:0] a1, input logic [15:0] a2, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_arg1 = a1; req_arg2 = a2;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!resp_valid && lat < 40) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lat, w0, r0;
    rst_n = 1'b0; req_valid = 1'b0; req_op = 2'd0; req_addr = '0;
    req_arg1 = '0; req_arg2 = '0; stall = 1'b0; tb_we = 1'b0; tb_wa = '0; tb_wd = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !mem_req && !mem_lock && !resp_valid && !hand_valid, "R1", "outputs in reset",
        {busy, mem_req, mem_lock, resp_valid, hand_valid}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !mem_req && !resp_valid && !hand_valid, "R1", "outputs idle after reset",
        {busy, mem_req, resp_valid, hand_valid}, 0);

    for (int i = 0; i < NV; i++) begin
      poke(VECS[i].addr, VECS[i].init);
      poke(FLAG_A, VECS[i].flag);
      w0 = wr_cnt; r0 = rd_cnt;
      issue(VECS[i].op, VECS[i].addr, 16'hA000 + 16'(i), 16'hB000 + 16'(i), lat);
      chk(lat == int'(VECS[i].lat), "R2-R7 latency", $sformatf("vec %0d cycles", i), lat, VECS[i].lat);
      chk(resp_valid && resp_slow == VECS[i].slow, "R9", $sformatf("vec %0d slow", i),
          resp_slow, VECS[i].slow);
      chk(resp_status == VECS[i].st, "R2", $sformatf("vec %0d status", i), resp_status, VECS[i].st);
      chk(hand_valid == VECS[i].slow, "R9", $sformatf("vec %0d hand_valid", i), hand_valid, VECS[i].slow);
      if (VECS[i].slow) begin
        chk(hand_op == VECS[i].op, "R3", $sformatf("vec %0d hand_op", i), hand_op, VECS[i].op);
        chk(hand_w0 == {8'h00, VECS[i].addr}, "R3", $sformatf("vec %0d hand_w0", i), hand_w0, VECS[i].addr);
        chk(hand_w1 == 16'hA000 + 16'(i) && hand_w2 == 16'hB000 + 16'(i), "R3",
            $sformatf("vec %0d hand_w1/w2", i), {hand_w1, hand_w2}, {16'hA000 + 16'(i), 16'hB000 + 16'(i)});
      end
      chk((wr_cnt - w0) == (VECS[i].slow ? 0 : 1), "R5", $sformatf("vec %0d write count", i),
          wr_cnt - w0, VECS[i].slow ? 0 : 1);
      if (VECS[i].op == 2'd2 && VECS[i].flag != 0)
        chk((rd_cnt - r0) == 1, "R6", "flag set reads only flag", rd_cnt - r0, 1);
      if (VECS[i].op == 2'd3)
        chk((rd_cnt - r0) == 0, "R12", "reserved op no read", rd_cnt - r0, 0);
      @(negedge clk);
      chk(!hand_valid && !resp_valid && !busy, "R9", $sformatf("vec %0d pulse ended", i),
          {hand_valid, resp_valid, busy}, 0);
      chk(mem[VECS[i].addr] == VECS[i].fin, "R4", $sformatf("vec %0d final lock", i),
          mem[VECS[i].addr], VECS[i].fin);
    end

    // R8 / R10: write-back stalled for three cycles
    poke(8'h20, 16'h8000);
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd0; req_addr = 8'h20;
    @(negedge clk);              // after accept edge: lat 1
    req_valid = 1'b0;
    @(negedge clk);              // lat 2: lock read data cycle
    chk(mem_lock, "R8", "lock raised after read grant", mem_lock, 1);
    @(negedge clk);              // lat 3: write requested
    stall = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(mem_req && mem_we && mem_lock, "R10", "write held while stalled",
          {mem_req, mem_we, mem_lock}, 3'b111);
    end
    stall = 1'b0;
    @(negedge clk);              // lat 7
    chk(resp_valid && !resp_slow && resp_status == 16'h1, "R8", "stalled enter completes at 7",
        {resp_valid, resp_slow, resp_status}, {2'b10, 16'h1});
    chk(!mem_lock, "R8", "lock released after write", mem_lock, 0);
    chk(lock_bad == 0, "R8", "writes issued unlocked", lock_bad, 0);
    chk(mem[8'h20] == 16'h0000, "R2", "stalled enter wrote held", mem[8'h20], 0);

    // R11: request while busy is ignored
    poke(8'h30, 16'h8000);
    poke(8'h31, 16'h0000);
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd0; req_addr = 8'h30;
    @(negedge clk);
    req_op = 2'd1; req_addr = 8'h31;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (resp_valid) lat++;
    end
    chk(lat == 1, "R11", "single response", lat, 1);
    chk(mem[8'h31] == 16'h0000, "R11", "busy request left lock", mem[8'h31], 0);
    chk(mem[8'h30] == 16'h0000, "R2", "first request done", mem[8'h30], 0);

    // R1: reset mid-operation returns to idle
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd0; req_addr = 8'h40;
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk(!busy && !mem_req && !mem_lock, "R1", "reset aborts", {busy, mem_req, mem_lock}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule